// File: doc/BRIEF.md
# Standby Wake-Up Settling Controller

This block steps a processor core and its peripherals between running, a light sleep and a deep standby. Software writes an 8-bit control register that holds a deep-standby select bit and a 3-bit settle-time field. When the core pulses the sleep-request strobe, the block reads the select bit in that cycle. If the bit is 0 it enters sleep. If it is 1 it enters standby.

A wake interrupt ends sleep at once. A wake interrupt in standby starts a settling period instead. During that period the run-enable output stays low for a fixed number of clock states, so the oscillator can stabilise before the core and peripherals run again. The field is latched when standby is entered, so the length of the wait cannot be changed once the block is on its way down.

Top module: `stby_wake_ctrl`

## Requirements
- R1: After reset, run_en is 1, in_sleep, in_standby and in_settle are 0, and cfg_rdata reads 8'h00.
- R2: A cycle with cfg_we high stores cfg_wdata bits 7 to 4, which read back unchanged on cfg_rdata from the next cycle on. Bits 3 to 0 of cfg_rdata always read 0, whatever is written.
- R3: With register bit 7 at 0, a sleep_req pulse sampled while running sets in_sleep and clears run_en from the next cycle on.
- R4: With register bit 7 at 1, a sleep_req pulse sampled while running sets in_standby and clears run_en from the next cycle on.
- R5: In sleep, a wake_irq sampled on a clock edge sets run_en again in the next cycle, with no settling wait.
- R6: In standby, a wake_irq sampled on a clock edge starts the settling period. in_settle is high for exactly N cycles, run_en stays low throughout, and run_en rises at the N-th edge after the wake was sampled.
- R7: N is set by register bits 6 to 4. Values 0 to 4 give 8192 times 2 to the power of the value (8192, 16384, 32768, 65536, 131072). Value 5 gives 1024, 6 gives 128 and 7 gives 16.
- R8: N is taken from the register at the edge where standby is entered. Register writes made during standby or settling do not change the wait in progress.
- R9: A sleep_req pulse while in sleep, standby or settling has no effect.
- R10: A wake_irq while running or while settling has no effect. It neither stops the block nor shortens the wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register read value |
| sleep_req | input | 1 | One-cycle strobe from the core's sleep instruction |
| wake_irq | input | 1 | Wake interrupt |
| in_sleep | output | 1 | Block is in sleep |
| in_standby | output | 1 | Block is in standby |
| in_settle | output | 1 | Settling wait in progress |
| run_en | output | 1 | Core and peripherals may run |

## Verification
The settling wait is measured for field values 7, 6, 5, 0 and 4. These give waits of 16, 128, 1024, 8192 and 131072. Between them they cover both arms of the non-monotonic encoding and both ends of the counter's range, so a swapped or shifted code shows up as a wrong cycle count.

A standby cycle is run with register rewrites in mid-wait, which separates a wait latched at entry from one that reads the live register. Another standby cycle gets extra wake pulses during settling, which would reveal a counter that restarts or ends early. Sleep entries interleaved with stray strobes in every mode show that mode changes happen only on the allowed inputs.

// File: rtl/swc_pkg.sv
package swc_pkg;

   typedef enum logic [1:0] {
      PM_RUN    = 2'd0,
      PM_NAP    = 2'd1,
      PM_DEEP   = 2'd2,
      PM_SETTLE = 2'd3
   } pm_state_t;

   localparam int SEL_W = 3;
   localparam int CNT_W = 17;

   // Terminal count (wait length minus one) for each settle-time code
   function automatic logic [CNT_W-1:0] settle_last(input logic [SEL_W-1:0] sel);
      logic [CNT_W:0] len;
      case (sel)
         3'd5:    len = 18'd1024;
         3'd6:    len = 18'd128;
         3'd7:    len = 18'd16;
         default: len = 18'd8192 << sel;
      endcase
      return len[CNT_W-1:0] - 1'b1;
   endfunction

endpackage

// File: rtl/swc_ctrl_reg.sv
module swc_ctrl_reg #(
   parameter int DATA_W   = 8,
   parameter int DEEP_BIT = 7,
   parameter int SEL_LSB  = 4,
   parameter int SEL_W    = swc_pkg::SEL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              deep_sel,
   output logic [SEL_W-1:0]  wait_sel
);
   localparam int SEL_MSB = SEL_LSB + SEL_W - 1;

   if (DEEP_BIT >= DATA_W) begin : g_chk_deep
      $error("deep-select bit lies outside the register");
   end
   if (SEL_MSB >= DEEP_BIT) begin : g_chk_sel
      $error("settle field overlaps or passes the deep-select bit");
   end

   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      if (b == DEEP_BIT || (b >= SEL_LSB && b <= SEL_MSB)) begin : g_ff
         logic r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  r <= 1'b0;
            else if (we) r <= wdata[b];
         end
         assign rdata[b] = r;
      end else begin : g_rsv
         assign rdata[b] = 1'b0;
      end
   end

   assign deep_sel = rdata[DEEP_BIT];
   assign wait_sel = rdata[SEL_MSB:SEL_LSB];

   AST_REG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (deep_sel == $past(wdata[DEEP_BIT])) && (wait_sel == $past(wdata[SEL_MSB:SEL_LSB]))); // R2

endmodule

// File: rtl/swc_settle_cnt.sv
module swc_settle_cnt
   import swc_pkg::*;
#(
   parameter int C_W = swc_pkg::CNT_W,
   parameter int S_W = swc_pkg::SEL_W
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load,
   input  logic [S_W-1:0] sel_in,
   input  logic           start,
   input  logic           run,
   output logic           done
);
   if (C_W < swc_pkg::CNT_W) begin : g_chk_w
      $error("counter too narrow for the longest wait");
   end
   if (S_W != swc_pkg::SEL_W) begin : g_chk_s
      $error("settle field width must match the encoding");
   end

   logic [S_W-1:0] sel_q;
   logic [C_W-1:0] cnt;
   logic [C_W-1:0] last;

   assign last = C_W'(settle_last(sel_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= '0;
         cnt   <= '0;
      end else begin
         if (load) sel_q <= sel_in;
         if (start)    cnt <= '0;
         else if (run) cnt <= cnt + 1'b1;
      end
   end

   assign done = run && (cnt == last);

   AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run)) |-> $stable(sel_q)); // R8
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt <= last)); // R6

endmodule

// File: rtl/swc_mode_fsm.sv
module swc_mode_fsm
   import swc_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      sleep_req,
   input  logic      wake_irq,
   input  logic      deep_sel,
   input  logic      cnt_done,
   output pm_state_t state,
   output logic      enter_deep,
   output logic      wake_deep
);
   pm_state_t nxt;

   assign enter_deep = (state == PM_RUN) && sleep_req && deep_sel;
   assign wake_deep  = (state == PM_DEEP) && wake_irq;

   always_comb begin
      nxt = state;
      case (state)
         PM_RUN:    if (sleep_req) nxt = deep_sel ? PM_DEEP : PM_NAP;
         PM_NAP:    if (wake_irq)  nxt = PM_RUN;
         PM_DEEP:   if (wake_irq)  nxt = PM_SETTLE;
         PM_SETTLE: if (cnt_done)  nxt = PM_RUN;
         default:   nxt = PM_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= PM_RUN;
      else        state <= nxt;
   end

   AST_NAP_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PM_NAP && wake_irq) |=> (state == PM_RUN)); // R5
   AST_DEEP_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PM_DEEP && wake_irq) |=> (state == PM_SETTLE)); // R6
   AST_NAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PM_NAP && !wake_irq) |=> (state == PM_NAP)); // R9
   AST_DEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PM_DEEP && !wake_irq) |=> (state == PM_DEEP)); // R9

endmodule

// File: rtl/stby_wake_ctrl.sv
module stby_wake_ctrl
   import swc_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int DEEP_BIT = 7,
   parameter int SEL_LSB  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic [DATA_W-1:0] cfg_rdata,
   input  logic              sleep_req,
   input  logic              wake_irq,
   output logic              in_sleep,
   output logic              in_standby,
   output logic              in_settle,
   output logic              run_en
);
   logic             deep_sel;
   logic [SEL_W-1:0] wait_sel;
   logic             enter_deep;
   logic             wake_deep;
   logic             cnt_done;
   pm_state_t        state;

   swc_ctrl_reg #(
      .DATA_W(DATA_W), .DEEP_BIT(DEEP_BIT), .SEL_LSB(SEL_LSB), .SEL_W(SEL_W)
   ) u_reg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
      .rdata(cfg_rdata), .deep_sel(deep_sel), .wait_sel(wait_sel)
   );

   swc_mode_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_irq(wake_irq),
      .deep_sel(deep_sel), .cnt_done(cnt_done), .state(state),
      .enter_deep(enter_deep), .wake_deep(wake_deep)
   );

   swc_settle_cnt #(.C_W(CNT_W), .S_W(SEL_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .load(enter_deep), .sel_in(wait_sel),
      .start(wake_deep), .run(state == PM_SETTLE), .done(cnt_done)
   );

   assign run_en     = (state == PM_RUN);
   assign in_sleep   = (state == PM_NAP);
   assign in_standby = (state == PM_DEEP);
   assign in_settle  = (state == PM_SETTLE);

   AST_ONE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({run_en, in_sleep, in_standby, in_settle}) == 1); // R1
   AST_RUN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && !sleep_req) |=> run_en); // R10
   AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && sleep_req && !deep_sel) |=> in_sleep); // R3
   AST_STANDBY_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && sleep_req && deep_sel) |=> in_standby); // R4

endmodule

// File: tb/stby_wake_ctrl_test.sv
`timescale 1ns/1ps
module stby_wake_ctrl_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [7:0] cfg_wdata = 8'h00;
   logic [7:0] cfg_rdata;
   logic       sleep_req = 1'b0;
   logic       wake_irq = 1'b0;
   logic       in_sleep, in_standby, in_settle, run_en;

   int checks = 0;
   int errors = 0;
   int exp_q[$];
   int run_len = 0;

   always #5 clk = ~clk;

   stby_wake_ctrl uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .sleep_req(sleep_req), .wake_irq(wake_irq),
      .in_sleep(in_sleep), .in_standby(in_standby), .in_settle(in_settle),
      .run_en(run_en)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int wait_len(input int sel);
      case (sel)
         5: return 1024;
         6: return 128;
         7: return 16;
         default: return 8192 * (1 << sel);
      endcase
   endfunction

   task automatic step();
      @(negedge clk);
   endtask

   task automatic write_cfg(input logic [7:0] v);
      cfg_we = 1'b1; cfg_wdata = v;
      step();
      cfg_we = 1'b0;
   endtask

   task automatic pulse_sleep();
      sleep_req = 1'b1; step(); sleep_req = 1'b0;
   endtask

   task automatic pulse_wake();
      wake_irq = 1'b1; step(); wake_irq = 1'b0;
   endtask

   task automatic wait_run();
      while (!run_en) step();
      step();
   endtask

   // Driver: enter standby with a given code, push the expected wait length, wake
   task automatic settle_case(input int sel, input string req);
      write_cfg({1'b1, 3'(sel), 4'h0});
      pulse_sleep();
      chk(in_standby && !run_en, req, {30'd0, in_standby, run_en}, 2);
      exp_q.push_back(wait_len(sel));
      pulse_wake();
      chk(in_settle && !run_en, "R6", {30'd0, in_settle, run_en}, 2);
      wait_run();
   endtask

   // Monitor: measure each settling run and compare with the queue head
   always @(negedge clk) begin
      if (in_settle) begin
         run_len++;
      end else if (run_len > 0) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R6", run_len, 0);
         end else begin
            int e;
            e = exp_q.pop_front();
            chk(run_len == e, "R7", run_len, e);
            chk(run_en, "R6", int'(run_en), 1);
         end
         run_len = 0;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) step();
      rst_n = 1'b1;
      step();
      // R1 reset state
      chk(run_en && !in_sleep && !in_standby && !in_settle, "R1",
          {28'd0, run_en, in_sleep, in_standby, in_settle}, 8);
      chk(cfg_rdata == 8'h00, "R1", cfg_rdata, 0);

      // R2 register write/readback, reserved bits zero
      write_cfg(8'hFF);
      chk(cfg_rdata == 8'hF0, "R2", cfg_rdata, 8'hF0);
      write_cfg(8'h5A);
      chk(cfg_rdata == 8'h50, "R2", cfg_rdata, 8'h50);

      // R3 sleep entry, R9 ignored strobe, R5 immediate wake
      write_cfg(8'h00);
      pulse_sleep();
      chk(in_sleep && !run_en, "R3", {30'd0, in_sleep, run_en}, 2);
      pulse_sleep();
      chk(in_sleep, "R9", int'(in_sleep), 1);
      pulse_wake();
      chk(run_en && !in_sleep, "R5", {30'd0, run_en, in_sleep}, 2);

      // R10 wake while running ignored
      pulse_wake();
      step();
      chk(run_en, "R10", int'(run_en), 1);

      // R4 standby entry, R9 strobe in standby ignored
      write_cfg(8'hF0);
      pulse_sleep();
      chk(in_standby && !run_en, "R4", {30'd0, in_standby, run_en}, 2);
      pulse_sleep();
      chk(in_standby, "R9", int'(in_standby), 1);
      exp_q.push_back(16);
      pulse_wake();
      wait_run();

      // R7 several codes
      settle_case(6, "R4");
      settle_case(5, "R4");
      settle_case(0, "R4");

      // R8 writes during standby and settling do not change the wait
      write_cfg(8'hF0);
      pulse_sleep();
      write_cfg(8'h80);
      chk(in_standby, "R8", int'(in_standby), 1);
      exp_q.push_back(16);
      pulse_wake();
      write_cfg(8'hC0);
      step();
      chk(in_settle, "R8", int'(in_settle), 1);
      wait_run();

      // R10 wake and sleep pulses during settling do not restart or shorten it
      write_cfg(8'hE0);
      pulse_sleep();
      exp_q.push_back(128);
      pulse_wake();
      repeat (5) step();
      pulse_wake();
      pulse_sleep();
      repeat (20) step();
      pulse_wake();
      chk(in_settle, "R10", int'(in_settle), 1);
      wait_run();

      // R7 longest wait
      settle_case(4, "R4");
      step();
      chk(exp_q.size() == 0, "R6", exp_q.size(), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule